// File: doc/BRIEF.md
# Multi-mode configurable I/O port

An eight-pin I/O port for a microcontroller's memory-mapped register bus. Each pin picks its own role. Under software control it behaves as a general-purpose pin, with an output enable and an output value held in registers. It can instead pass a programmable-logic output and enable through to the pad. It can also drive one bit of a latched address. A single mode bit overrides every per-pin setting and turns the whole port into a tri-state bidirectional buffer for the CPU data bus. That buffer conducts only while a peripheral select is asserted.

Pad levels always reach the logic side unchanged. Software reads them through a two-flop synchronizer. A build parameter removes the control register: every pin is then a software pin unless the logic claims it for address output.

Top module: `cfg_io_port`

## Requirements
- R1: After reset the control (offset 0), direction (offset 1), data-out (offset 2) and mode (offset 4) registers read 0, and no pad is driven.
- R2: Offsets 0, 1 and 2 read back the full byte last written. Offset 4 holds only its top bit (bit 7), and the other seven bits read 0. A write to offset 3 changes nothing, and any offset above 4 reads 0.
- R3: With the mode bit clear, a pin whose control bit is 0 and which is not an active address pin takes its output enable from its direction bit and its output from its data-out bit.
- R4: Offset 3 returns the pad levels two rising clock edges after they change, in every mode. It still shows the old value after one edge.
- R5: With the mode bit clear, a pin with control bit 1 that is not an active address pin drives `lg_out`. Its enable is `lg_oe` ANDed with its direction bit.
- R6: A pin with `pin_addr_sel` set becomes an active address pin when its `lg_oe` bit is 1, or when its control and direction bits are both 1. It then drives `addr_lat` with the output enabled, and this takes priority over logic and software modes.
- R7: With the mode bit set and both bits of `psel` at 0, no pad is driven and `cpu_rdata` is 0.
- R8: With the mode bit set and either select bit at 1, `cpu_wr`=1 drives `cpu_wdata` on all pins with all enables on. `cpu_wr`=0 releases all pins and presents `pad_in` on `cpu_rdata`.
- R9: The mode bit overrides every per-pin address, logic and software setting.
- R10: With `HAS_CTRL`=0, offset 0 always reads 0 and writes to it are ignored. The pins behave as software pins.
- R11: `lg_in` follows `pad_in` combinationally in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register offset |
| reg_wdata | input | W | Register write data |
| reg_rdata | output | W | Register read data (combinational) |
| addr_lat | input | W | Latched address bits for address output |
| cpu_wdata | input | W | CPU data bus, write direction |
| cpu_rdata | output | W | Buffered pad data toward the CPU |
| cpu_wr | input | 1 | 1 = CPU write cycle, 0 = read cycle |
| psel | input | 2 | Peripheral selects, active high |
| lg_out | input | W | Logic-side output values |
| lg_oe | input | W | Logic-side output enable terms |
| pin_addr_sel | input | W | Pins the logic assigns to address output |
| lg_in | output | W | Pad levels toward the logic |
| pad_in | input | W | Pad input levels |
| pad_out | output | W | Pad output values |
| pad_oe | output | W | Pad output enables |

## Verification
The hardest case to reach is a single pin that qualifies for address output and for logic mode at the same time, because the priority between the two only shows when both conditions hold together. The stimulus sets the control bits high and raises `lg_oe` on a pin that has `pin_addr_sel` set but a direction bit of 0. In that state logic mode alone would release the pin, so the pad value and enable reveal which mode won. A second instance built with `HAS_CTRL`=0 gets the same writes, so both variants are compared on identical stimulus.

// File: rtl/cfg_io_port.sv
module cfg_io_port #(
  parameter int W        = 8,
  parameter int AW       = 3,
  parameter bit HAS_CTRL = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata,
  input  logic [W-1:0]  addr_lat,
  input  logic [W-1:0]  cpu_wdata,
  output logic [W-1:0]  cpu_rdata,
  input  logic          cpu_wr,
  input  logic [1:0]    psel,
  input  logic [W-1:0]  lg_out,
  input  logic [W-1:0]  lg_oe,
  input  logic [W-1:0]  pin_addr_sel,
  output logic [W-1:0]  lg_in,
  input  logic [W-1:0]  pad_in,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_oe
);

  localparam logic [AW-1:0] OFS_CTRL = AW'(0);
  localparam logic [AW-1:0] OFS_DIR  = AW'(1);
  localparam logic [AW-1:0] OFS_DOUT = AW'(2);
  localparam logic [AW-1:0] OFS_DIN  = AW'(3);
  localparam logic [AW-1:0] OFS_MODE = AW'(4);

  logic [W-1:0] ctrl_q, dir_q, dout_q, sync1_q, din_q;
  logic         pbuf_en;
  logic [W-1:0] addr_act, logic_pin, sw_pin, pp_out, pp_oe;
  logic         sel_any;

  generate
    if (HAS_CTRL) begin : g_ctrl
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) ctrl_q <= '0;
        else if (reg_we && reg_addr == OFS_CTRL) ctrl_q <= reg_wdata;
    end else begin : g_noctrl
      assign ctrl_q = '0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      dout_q  <= '0;
      pbuf_en <= 1'b0;
      sync1_q <= '0;
      din_q   <= '0;
    end else begin
      sync1_q <= pad_in;
      din_q   <= sync1_q;
      if (reg_we) begin
        if (reg_addr == OFS_DIR)  dir_q   <= reg_wdata;
        if (reg_addr == OFS_DOUT) dout_q  <= reg_wdata;
        if (reg_addr == OFS_MODE) pbuf_en <= reg_wdata[W-1];
      end
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_CTRL: reg_rdata = ctrl_q;
      OFS_DIR:  reg_rdata = dir_q;
      OFS_DOUT: reg_rdata = dout_q;
      OFS_DIN:  reg_rdata = din_q;
      OFS_MODE: reg_rdata = {pbuf_en, {(W-1){1'b0}}};
      default:  reg_rdata = '0;
    endcase
  end

  assign addr_act  = pin_addr_sel & (lg_oe | (ctrl_q & dir_q));
  assign logic_pin = ctrl_q & ~addr_act;
  assign sw_pin    = ~ctrl_q & ~addr_act;

  assign pp_out = (addr_act & addr_lat) | (logic_pin & lg_out) | (sw_pin & dout_q);
  assign pp_oe  = addr_act | (logic_pin & lg_oe & dir_q) | (sw_pin & dir_q);

  assign sel_any   = |psel;
  assign pad_out   = pbuf_en ? cpu_wdata : pp_out;
  assign pad_oe    = pbuf_en ? {W{sel_any & cpu_wr}} : pp_oe;
  assign cpu_rdata = (pbuf_en && sel_any && !cpu_wr) ? pad_in : '0;
  assign lg_in     = pad_in;

endmodule

// File: rtl/cfg_io_port_chk.sv
module cfg_io_port_chk #(
  parameter int W        = 8,
  parameter bit HAS_CTRL = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   psel,
  input logic         cpu_wr,
  input logic [W-1:0] cpu_wdata,
  input logic [W-1:0] pad_in,
  input logic [W-1:0] pad_out,
  input logic [W-1:0] pad_oe,
  input logic [W-1:0] pin_addr_sel,
  input logic         pbuf_en,
  input logic [W-1:0] ctrl_q,
  input logic [W-1:0] dir_q,
  input logic [W-1:0] dout_q,
  input logic [W-1:0] din_q
);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ctrl_q == '0 && dir_q == '0 && dout_q == '0 && !pbuf_en));

  assert_sw_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !pbuf_en |-> ((pad_oe & ~ctrl_q & ~pin_addr_sel) == (dir_q & ~ctrl_q & ~pin_addr_sel)));

  assert_din_two_stage_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2)) |-> din_q == $past(pad_in, 2));

  assert_buffer_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pbuf_en && psel == 2'b00) |-> pad_oe == '0);

  assert_buffer_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pbuf_en && psel != 2'b00 && cpu_wr) |-> (pad_oe == '1 && pad_out == cpu_wdata));

  generate
    if (!HAS_CTRL) begin : g_noctrl
      assert_no_ctrl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q == '0);
    end
  endgenerate

endmodule

bind cfg_io_port cfg_io_port_chk #(.W(W), .HAS_CTRL(HAS_CTRL)) u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
  .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pin_addr_sel(pin_addr_sel),
  .pbuf_en(pbuf_en), .ctrl_q(ctrl_q), .dir_q(dir_q), .dout_q(dout_q), .din_q(din_q)
);

// File: tb/tb_cfg_io_port.sv
module tb_cfg_io_port;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, addr_lat = 0, cpu_wdata = 0, lg_out = 0, lg_oe = 0;
  logic [7:0] pin_addr_sel = 0, pad_in = 0;
  logic cpu_wr = 0;
  logic [1:0] psel = 0;
  logic [7:0] reg_rdata, cpu_rdata, lg_in, pad_out, pad_oe;
  logic [7:0] reg_rdata2, cpu_rdata2, lg_in2, pad_out2, pad_oe2;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_io_port dut (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .addr_lat(addr_lat), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_wr(cpu_wr), .psel(psel), .lg_out(lg_out), .lg_oe(lg_oe),
    .pin_addr_sel(pin_addr_sel), .lg_in(lg_in), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe));

  cfg_io_port #(.HAS_CTRL(1'b0)) dut2 (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata2), .addr_lat(addr_lat), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata2), .cpu_wr(cpu_wr), .psel(psel), .lg_out(lg_out), .lg_oe(lg_oe),
    .pin_addr_sel(pin_addr_sel), .lg_in(lg_in2), .pad_in(pad_in), .pad_out(pad_out2), .pad_oe(pad_oe2));

  int         q_kind[$];
  logic [7:0] q_exp[$];
  string      q_tag[$];
  int n_total = 0, n_fail = 0;
  bit done = 0;

  function automatic logic [7:0] observe(int k);
    case (k)
      0: return pad_oe;
      1: return pad_out;
      2: return reg_rdata;
      3: return cpu_rdata;
      4: return lg_in;
      5: return pad_oe2;
      6: return pad_out2;
      default: return reg_rdata2;
    endcase
  endfunction

  always @(negedge clk) begin
    while (q_kind.size() > 0) begin
      int k;
      logic [7:0] e, a;
      string t;
      k = q_kind.pop_front();
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      a = observe(k);
      n_total++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s (kind %0d): actual %h expected %h", t, k, a, e);
      end
    end
  end

  task automatic expect_val(int k, logic [7:0] e, string t);
    q_kind.push_back(k); q_exp.push_back(e); q_tag.push_back(t);
  endtask

  task automatic step();
    @(negedge clk); #1;
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 0;
  endtask

  task automatic rd(logic [2:0] a, logic [7:0] e, string t, bit second = 0);
    reg_addr = a;
    expect_val(second ? 7 : 2, e, t);
    step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;

    expect_val(0, 8'h00, "R1 no pad driven");
    rd(3'd0, 8'h00, "R1 ctrl reset");
    rd(3'd1, 8'h00, "R1 dir reset");
    rd(3'd2, 8'h00, "R1 dout reset");
    rd(3'd4, 8'h00, "R1 mode reset");

    wr(3'd0, 8'hA5); rd(3'd0, 8'hA5, "R2 ctrl readback");
    wr(3'd1, 8'h3C); rd(3'd1, 8'h3C, "R2 dir readback");
    wr(3'd2, 8'hF0); rd(3'd2, 8'hF0, "R2 dout readback");
    wr(3'd4, 8'h7F); rd(3'd4, 8'h00, "R2 mode low bits");
    wr(3'd4, 8'h80); rd(3'd4, 8'h80, "R2 mode top bit");
    wr(3'd4, 8'h00);
    wr(3'd3, 8'h55); rd(3'd3, 8'h00, "R2 din write ignored");
    rd(3'd5, 8'h00, "R2 unused offset");
    rd(3'd0, 8'h00, "R10 ctrl absent", 1);

    wr(3'd0, 8'h00); wr(3'd1, 8'h0F); wr(3'd2, 8'hA5);
    expect_val(0, 8'h0F, "R3 sw enable");
    expect_val(1, 8'hA5, "R3 sw value");
    step();
    wr(3'd1, 8'hF0);
    expect_val(0, 8'hF0, "R3 sw enable pattern 2");
    step();

    wr(3'd0, 8'hFF); wr(3'd1, 8'hFF);
    lg_out = 8'h3C; lg_oe = 8'h0F; #1;
    expect_val(0, 8'h0F, "R5 logic enable");
    expect_val(1, 8'h3C, "R5 logic value");
    expect_val(5, 8'hFF, "R10 sw enable without ctrl");
    expect_val(6, 8'hA5, "R10 sw value without ctrl");
    step();
    wr(3'd1, 8'hF0);
    expect_val(0, 8'hF0 & 8'h0F, "R5 dir gates logic enable");
    step();

    wr(3'd1, 8'h01);
    lg_out = 8'h00; lg_oe = 8'h00; pin_addr_sel = 8'h03; addr_lat = 8'h55; #1;
    expect_val(0, 8'h01, "R6 addr via ctrl and dir");
    expect_val(1, 8'h01, "R6 addr value");
    step();
    lg_oe = 8'h02; addr_lat = 8'h57; #1;
    expect_val(0, 8'h03, "R6 addr via logic enable over logic mode");
    expect_val(1, 8'h03, "R6 addr value priority");
    step();

    pad_in = 8'h96; #1;
    expect_val(4, 8'h96, "R11 pass-through");
    rd(3'd3, 8'h00, "R4 din before edges");
    rd(3'd3, 8'h00, "R4 din after one edge");
    rd(3'd3, 8'h96, "R4 din after two edges");

    wr(3'd4, 8'h80);
    psel = 2'b00; cpu_wr = 1; cpu_wdata = 8'hC3; #1;
    expect_val(0, 8'h00, "R7 idle buffer released, R9 override");
    expect_val(3, 8'h00, "R7 idle read path");
    step();
    psel = 2'b01; #1;
    expect_val(0, 8'hFF, "R8 write enables");
    expect_val(1, 8'hC3, "R8 write data");
    step();
    cpu_wr = 0; psel = 2'b10; #1;
    expect_val(0, 8'h00, "R8 read released");
    expect_val(3, 8'h96, "R8 read data");
    expect_val(4, 8'h96, "R11 pass-through in buffer mode");
    step();
    rd(3'd3, 8'h96, "R4 din in buffer mode");

    @(negedge clk); #1;
    done = 1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_total++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end
endmodule